// File: doc/BRIEF.md
# Two-Channel Converter Register Target on a Two-Wire Serial Bus

This block is the target side of a two-wire serial bus (I2C) that feeds a small bank of converter settings. A fast system clock oversamples the bus clock and data lines. From those samples the block finds bus conditions, shifts bytes in and out, and answers a fixed 7-bit device address. A write frame carries one command byte and a 16-bit data word. The command either fills a channel's staging register or copies staging into the live register that drives the converter. A third command picks a staging register that a following read returns.

Each channel has two levels. The staging level takes new codes. The live level changes only on a copy command, so several channels can be moved together. Nothing is committed until the frame closes with a STOP, so a cut-off frame leaves every setting as it was. The data line is driven open-drain only: the block asserts an enable that pulls the line low, and otherwise releases it.

Top module: `i2c_dac_target`

## Requirements
- R1: After reset both staging and live values of every channel are zero and `sda_oe` is low. A falling data line while the clock is high is a START. A rising data line while the clock is high is a STOP.
- R2: The first byte after a START is compared with `DEV_ADDR` in bits 7..1, with bit 0 = 1 meaning read. On a match the block pulls the data line low for the ninth clock. On a mismatch it never pulls the line low until the next START, and the frame changes nothing.
- R3: A write frame is the address byte, a command byte with bits 7..4 = 0x1 and channel select in bits 3..0, then the data word high byte first. Every byte is acknowledged. After the closing STOP the selected channel's staging value equals data bits 15..4, and live values are unchanged.
- R4: A command with bits 7..4 = 0x2 copies the staging value of the selected channel into its live value at the closing STOP. The data word is still required and its value is ignored.
- R5: Channel select 0xF applies a write or copy command to all channels at once.
- R6: A command is applied only at a STOP that follows the complete data word. A STOP that comes earlier leaves every staging and live value unchanged.
- R7: A START followed by a STOP within the same clock-high phase is taken as a START alone, and the bits that follow are parsed as an address byte.
- R8: A command with bits 7..4 = 0x9, followed by a repeated START and a read address, selects the channel in bits 3..0 (0xF selects channel 0). The block then sends that channel's staging value left-justified in 16 bits, MSB first, high byte then low byte. On each master acknowledge it continues with the other byte. On a master NACK it releases the line.
- R9: A STOP during a read byte abandons the read. The next read starts again at the high byte.
- R10: The block never drives the line high. It starts pulling the line low only while the sampled clock is low, and it has released the line one cycle after any STOP.
- R11: A command with an unknown upper nibble, or a channel select that is neither a valid channel nor 0xF, is acknowledged like any other byte and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull-low enable for the open-drain data line |
| staged_flat | output | NCH*VAL_W | Staging values, channel 0 in the low bits |
| live_flat | output | NCH*VAL_W | Live values, channel 0 in the low bits |

## Verification
The bench builds the block with `DEV_ADDR` = 7'h1C, `NCH` = 2, `VAL_W` = 12 and `SYNC_STAGES` = 2. With two channels, the all-channel select can be told apart from a single-channel select, and a select of 3 falls outside the bank, so both the broadcast and the invalid-channel paths are exercised. A 12-bit value inside a 16-bit word means the dropped low nibble of a write and the zero nibble in the readback low byte are both visible at the ports. The bus runs at a quarter-bit time of 15 system clocks, which keeps every level well above the two-flop synchroniser delay while the START/STOP pairing inside one clock-high phase stays observable.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;

    localparam logic [3:0] OP_STAGE = 4'h1;
    localparam logic [3:0] OP_LOAD  = 4'h2;
    localparam logic [3:0] OP_PICK  = 4'h9;
    localparam logic [3:0] SEL_ALL  = 4'hF;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_CMD,
        PH_CMD_ACK,
        PH_DHI,
        PH_DHI_ACK,
        PH_DLO,
        PH_DLO_ACK,
        PH_HOLD,
        PH_TX,
        PH_TX_ACK,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic        scl_rise;
        logic        scl_fall;
        logic        start;
        logic        stop;
        logic        sda;
    } bus_ev_t;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [15:0] word;
    } frame_t;

    function automatic logic chan_hit(input logic [3:0] sel, input int ch);
        return (sel == SEL_ALL) || (sel == ch[3:0]);
    endfunction

    function automatic logic op_known(input logic [3:0] op);
        return (op == OP_STAGE) || (op == OP_LOAD);
    endfunction

endpackage

// File: rtl/bus_sense.sv
module bus_sense
    import i2c_dac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev,
    output logic    scl_lvl
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_s, sda_s, scl_d, sda_d;
    logic start_in_high;
    logic start_raw, stop_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    assign start_raw = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_raw  = scl_s & scl_d & ~sda_d & sda_s;

    // a START seen in this clock-high phase masks a STOP in the same phase
    always_ff @(posedge clk) begin
        if (rst) begin
            start_in_high <= 1'b0;
        end else if (~scl_s) begin
            start_in_high <= 1'b0;
        end else if (start_raw) begin
            start_in_high <= 1'b1;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = start_raw;
        ev.stop     = stop_raw & ~start_in_high;
        ev.sda      = sda_s;
    end

    assign scl_lvl = scl_s;

endmodule

// File: rtl/frame_engine.sv
module frame_engine
    import i2c_dac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h1C
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_ev_t     ev,
    input  logic [15:0] rd_word,
    output logic        sda_oe,
    output frame_t      frame,
    output logic        commit,
    output logic        pick_we
);

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    phase_t      phase;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic [7:0]  txreg;
    logic        rd_mode;
    logic        byte_sel;
    logic        mack;
    logic        have_cmd;
    logic        byte_done;
    logic [7:0]  next_tx;

    assign byte_done = (bitcnt == BITS_PER_BYTE);
    assign next_tx   = byte_sel ? rd_word[15:8] : rd_word[7:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            rd_mode  <= 1'b0;
            byte_sel <= 1'b0;
            mack     <= 1'b1;
            have_cmd <= 1'b0;
            sda_oe   <= 1'b0;
            frame    <= '0;
            commit   <= 1'b0;
            pick_we  <= 1'b0;
        end else begin
            commit  <= 1'b0;
            pick_we <= 1'b0;
            if (ev.start) begin
                pick_we  <= have_cmd && (frame.cmd[7:4] == OP_PICK);
                phase    <= PH_ADDR;
                bitcnt   <= '0;
                sda_oe   <= 1'b0;
                have_cmd <= 1'b0;
                byte_sel <= 1'b0;
            end else if (ev.stop) begin
                commit   <= (phase == PH_HOLD);
                phase    <= PH_IDLE;
                sda_oe   <= 1'b0;
                have_cmd <= 1'b0;
            end else if (ev.scl_rise) begin
                case (phase)
                    PH_ADDR, PH_CMD, PH_DHI, PH_DLO: begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    PH_TX:     bitcnt <= bitcnt + 4'd1;
                    PH_TX_ACK: mack   <= ev.sda;
                    default: ;
                endcase
            end else if (ev.scl_fall) begin
                case (phase)
                    PH_ADDR: begin
                        if (byte_done) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                rd_mode <= shreg[0];
                                sda_oe  <= 1'b1;
                                phase   <= PH_ADDR_ACK;
                            end else begin
                                phase   <= PH_SKIP;
                            end
                        end
                    end
                    PH_CMD: begin
                        if (byte_done) begin
                            frame.cmd <= shreg;
                            have_cmd  <= 1'b1;
                            sda_oe    <= 1'b1;
                            phase     <= PH_CMD_ACK;
                        end
                    end
                    PH_DHI: begin
                        if (byte_done) begin
                            frame.word[15:8] <= shreg;
                            sda_oe           <= 1'b1;
                            phase            <= PH_DHI_ACK;
                        end
                    end
                    PH_DLO: begin
                        if (byte_done) begin
                            frame.word[7:0] <= shreg;
                            sda_oe          <= 1'b1;
                            phase           <= PH_DLO_ACK;
                        end
                    end
                    PH_ADDR_ACK: begin
                        bitcnt <= '0;
                        if (rd_mode) begin
                            txreg  <= rd_word[15:8];
                            sda_oe <= ~rd_word[15];
                            phase  <= PH_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= PH_CMD;
                        end
                    end
                    PH_CMD_ACK: begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        phase  <= PH_DHI;
                    end
                    PH_DHI_ACK: begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        phase  <= PH_DLO;
                    end
                    PH_DLO_ACK: begin
                        sda_oe <= 1'b0;
                        phase  <= PH_HOLD;
                    end
                    PH_TX: begin
                        if (byte_done) begin
                            sda_oe <= 1'b0;
                            phase  <= PH_TX_ACK;
                        end else begin
                            txreg  <= {txreg[6:0], 1'b0};
                            sda_oe <= ~txreg[6];
                        end
                    end
                    PH_TX_ACK: begin
                        if (!mack) begin
                            byte_sel <= ~byte_sel;
                            txreg    <= next_tx;
                            sda_oe   <= ~next_tx[7];
                            bitcnt   <= '0;
                            phase    <= PH_TX;
                        end else begin
                            sda_oe   <= 1'b0;
                            phase    <= PH_SKIP;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import i2c_dac_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int VAL_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit,
    input  logic                 pick_we,
    input  frame_t               frame,
    output logic [15:0]          rd_word,
    output logic [NCH*VAL_W-1:0] staged_flat,
    output logic [NCH*VAL_W-1:0] live_flat
);

    localparam int PW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [VAL_W-1:0] staged [NCH];
    logic [VAL_W-1:0] live   [NCH];
    logic [PW-1:0]    ptr;
    logic [3:0]       op;
    logic [3:0]       sel;
    logic             sel_ok;

    assign op     = frame.cmd[7:4];
    assign sel    = frame.cmd[3:0];
    assign sel_ok = (sel == SEL_ALL) || (int'(sel) < NCH);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                staged[ch] <= '0;
                live[ch]   <= '0;
            end else if (commit && op_known(op) && chan_hit(sel, ch)) begin
                if (op == OP_STAGE) begin
                    staged[ch] <= frame.word[15 -: VAL_W];
                end
                if (op == OP_LOAD) begin
                    live[ch] <= staged[ch];
                end
            end
        end
        assign staged_flat[ch*VAL_W +: VAL_W] = staged[ch];
        assign live_flat[ch*VAL_W +: VAL_W]   = live[ch];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (pick_we && sel_ok) begin
            ptr <= (sel == SEL_ALL) ? '0 : sel[PW-1:0];
        end
    end

    always_comb begin
        rd_word             = '0;
        rd_word[15 -: VAL_W] = staged[ptr];
    end

endmodule

// File: rtl/i2c_dac_target.sv
module i2c_dac_target
    import i2c_dac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h1C,
    parameter int         NCH         = 2,
    parameter int         VAL_W       = 12,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    output logic [NCH*VAL_W-1:0] staged_flat,
    output logic [NCH*VAL_W-1:0] live_flat
);

    bus_ev_t     bev;
    logic        scl_lvl;
    frame_t      frame;
    logic        commit;
    logic        pick_we;
    logic [15:0] rd_word;

    bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .ev      (bev),
        .scl_lvl (scl_lvl)
    );

    frame_engine #(.DEV_ADDR(DEV_ADDR)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .ev      (bev),
        .rd_word (rd_word),
        .sda_oe  (sda_oe),
        .frame   (frame),
        .commit  (commit),
        .pick_we (pick_we)
    );

    reg_bank #(.NCH(NCH), .VAL_W(VAL_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .pick_we     (pick_we),
        .frame       (frame),
        .rd_word     (rd_word),
        .staged_flat (staged_flat),
        .live_flat   (live_flat)
    );

endmodule

// File: rtl/i2c_dac_target_chk.sv
module i2c_dac_target_chk #(
    parameter int NCH   = 2,
    parameter int VAL_W = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 scl_lvl,
    input logic                 sda_oe,
    input logic                 stop_evt,
    input logic                 commit,
    input logic [NCH*VAL_W-1:0] staged_flat,
    input logic [NCH*VAL_W-1:0] live_flat
);

    assert_staged_moves_on_commit_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(staged_flat) |-> $past(commit));

    assert_live_moves_on_commit_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(live_flat) |-> $past(commit));

    assert_commit_follows_stop_R6: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(stop_evt));

    assert_pull_low_only_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);

    assert_release_after_stop_R9: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);

endmodule

bind i2c_dac_target i2c_dac_target_chk #(.NCH(NCH), .VAL_W(VAL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_lvl     (scl_lvl),
    .sda_oe      (sda_oe),
    .stop_evt    (bev.stop),
    .commit      (commit),
    .staged_flat (staged_flat),
    .live_flat   (live_flat)
);

// File: tb/sim_i2c_dac_target.sv
`timescale 1ns/1ps
module sim_i2c_dac_target;

    localparam logic [6:0] TGT   = 7'h1C;
    localparam int         NCH   = 2;
    localparam int         VAL_W = 12;
    localparam int         Q     = 15;

    // cmd[71:64] word[63:48] staged0[47:36] staged1[35:24] live0[23:12] live1[11:0]
    localparam logic [71:0] VEC [9] = '{
        72'h10_ABC0_ABC_000_000_000,
        72'h11_1235_ABC_123_000_000,
        72'h20_0000_ABC_123_ABC_000,
        72'h1F_5A50_5A5_5A5_ABC_000,
        72'h21_FFFF_5A5_5A5_ABC_5A5,
        72'h37_7770_5A5_5A5_ABC_5A5,
        72'h13_9990_5A5_5A5_ABC_5A5,
        72'h2F_0000_5A5_5A5_5A5_5A5,
        72'h10_FFF0_FFF_5A5_5A5_5A5
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [NCH*VAL_W-1:0] staged_flat;
    logic [NCH*VAL_W-1:0] live_flat;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_dac_target #(.DEV_ADDR(TGT), .NCH(NCH), .VAL_W(VAL_W), .SYNC_STAGES(2)) u0 (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .staged_flat (staged_flat),
        .live_flat   (live_flat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic clk_pulse(output logic seen);
        wq();
        m_scl = 1'b1; wq();
        seen = sda_bus;
        wq();
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i];
            clk_pulse(s);
        end
        m_sda = 1'b1;
        clk_pulse(nack);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clk_pulse(s);
            b[i] = s;
        end
        m_sda = give_ack ? 1'b0 : 1'b1;
        clk_pulse(s);
        wq();
        m_sda = 1'b1;
    endtask

    task automatic write_frame(input logic [7:0] cmd, input logic [15:0] w, output logic [3:0] nacks);
        bus_start();
        send_byte({TGT, 1'b0}, nacks[3]);
        send_byte(cmd, nacks[2]);
        send_byte(w[15:8], nacks[1]);
        send_byte(w[7:0], nacks[0]);
        bus_stop();
        wq();
    endtask

    initial begin
        logic [3:0] nk;
        logic       n1;
        logic [7:0] rb;
        logic       s;

        repeat (5) @(negedge clk);
        chk("R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);
        chk("R1 reset staged", {8'd0, staged_flat}, 32'd0);
        chk("R1 reset live", {8'd0, live_flat}, 32'd0);
        rst = 1'b0;
        wq();

        // R3 R4 R5 R11 table walk
        for (int v = 0; v < 9; v++) begin
            write_frame(VEC[v][71:64], VEC[v][63:48], nk);
            chk($sformatf("R3 R11 acks vec%0d", v), {28'd0, nk}, 32'd0);
            chk($sformatf("R3 R5 R11 staged vec%0d", v), {8'd0, staged_flat},
                {8'd0, VEC[v][35:24], VEC[v][47:36]});
            chk($sformatf("R4 R5 R11 live vec%0d", v), {8'd0, live_flat},
                {8'd0, VEC[v][11:0], VEC[v][23:12]});
        end

        // R2 mismatched address
        bus_start();
        send_byte({7'h22, 1'b0}, n1);
        chk("R2 mismatch nack", {31'd0, n1}, 32'd1);
        send_byte(8'h10, n1);
        chk("R2 ignored cmd nack", {31'd0, n1}, 32'd1);
        send_byte(8'h00, n1);
        send_byte(8'h00, n1);
        bus_stop(); wq();
        chk("R2 no change", {8'd0, staged_flat}, {8'd0, 12'h5A5, 12'hFFF});

        // R6 early stop after high byte
        bus_start();
        send_byte({TGT, 1'b0}, n1);
        send_byte(8'h10, n1);
        send_byte(8'h12, n1);
        bus_stop(); wq();
        chk("R6 early stop staged", {8'd0, staged_flat}, {8'd0, 12'h5A5, 12'hFFF});

        // R6 copy command without data word
        bus_start();
        send_byte({TGT, 1'b0}, n1);
        send_byte(8'h20, n1);
        bus_stop(); wq();
        chk("R6 early stop live", {8'd0, live_flat}, {8'd0, 12'h5A5, 12'h5A5});

        // R7 START and STOP in one clock-high phase
        m_sda = 1'b0; wq();
        m_sda = 1'b1; wq();
        m_scl = 1'b0; wq();
        send_byte({TGT, 1'b0}, nk[3]);
        send_byte(8'h11, nk[2]);
        send_byte(8'h45, nk[1]);
        send_byte(8'h60, nk[0]);
        bus_stop(); wq();
        chk("R7 paired start acks", {28'd0, nk}, 32'd0);
        chk("R7 paired start staged", {8'd0, staged_flat}, {8'd0, 12'h456, 12'hFFF});

        // R8 readback channel 0 with wrap
        bus_start();
        send_byte({TGT, 1'b0}, n1);
        send_byte(8'h90, n1);
        bus_rstart();
        send_byte({TGT, 1'b1}, n1);
        chk("R8 read addr ack", {31'd0, n1}, 32'd0);
        recv_byte(1'b1, rb);
        chk("R8 ch0 high byte", {24'd0, rb}, 32'h0000_00FF);
        recv_byte(1'b1, rb);
        chk("R8 ch0 low byte", {24'd0, rb}, 32'h0000_00F0);
        recv_byte(1'b0, rb);
        chk("R8 ch0 wrap byte", {24'd0, rb}, 32'h0000_00FF);
        chk("R8 released after nack", {31'd0, sda_oe}, 32'd0);
        bus_stop(); wq();
        chk("R10 idle released", {31'd0, sda_oe}, 32'd0);
        chk("R10 bus high", {31'd0, sda_bus}, 32'd1);

        // R8 readback channel 1
        bus_start();
        send_byte({TGT, 1'b0}, n1);
        send_byte(8'h91, n1);
        bus_rstart();
        send_byte({TGT, 1'b1}, n1);
        recv_byte(1'b1, rb);
        chk("R8 ch1 high byte", {24'd0, rb}, 32'h0000_0045);
        recv_byte(1'b0, rb);
        chk("R8 ch1 low byte", {24'd0, rb}, 32'h0000_0060);
        bus_stop(); wq();

        // R9 stop inside second read byte, then fresh read
        bus_start();
        send_byte({TGT, 1'b0}, n1);
        send_byte(8'h90, n1);
        bus_rstart();
        send_byte({TGT, 1'b1}, n1);
        recv_byte(1'b1, rb);
        for (int k = 0; k < 3; k++) begin
            clk_pulse(s);
        end
        wq();
        bus_stop(); wq();
        chk("R9 released after abort", {31'd0, sda_oe}, 32'd0);
        bus_start();
        send_byte({TGT, 1'b1}, n1);
        chk("R9 read addr ack", {31'd0, n1}, 32'd0);
        recv_byte(1'b0, rb);
        chk("R9 restart from high byte", {24'd0, rb}, 32'h0000_00FF);
        bus_stop(); wq();
        chk("R9 registers intact", {8'd0, staged_flat}, {8'd0, 12'h456, 12'hFFF});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule